// File: doc/BRIEF.md
# Oscillator Source Selector

This block picks which of two oscillators paces the processor: an external crystal or an on-chip RC oscillator. Each oscillator arrives as a one-cycle clock-enable tick on the system clock. The block forwards the ticks of the source in use as a single clock enable. Switching is done on enable pulses; there is no analog clock multiplexing.

Software controls the block through a small register write: a source-select bit (1 = crystal, 0 = RC) and an amplifier-off bit. It reads back both bits, a status bit that shows the source actually in use, and a crystal-ready flag. Hardware raises the crystal-ready flag after a programmable number of crystal ticks. A request to change source takes effect only after one instruction cycle of the old source. Here one instruction cycle is `INSTR_TICKS` enable ticks. The select bit refuses the crystal until the crystal-ready flag is set. The amplifier may be turned off only while the RC oscillator is running, and turning it off restarts the warm-up.

Top module: `osc_source_select`

## Requirements
- R1: On synchronous reset the select bit is 0, the status bit shows RC, the amplifier-off bit is 0 (amp_en = 1) and xtal_ready is 0. clk_en then follows rc_tick.
- R2: clk_en equals rc_tick while the status bit is 0. It equals xtal_tick gated by amp_en while the status bit is 1. There is no register delay on this path.
- R3: A write with cfg_sel = 1 while xtal_ready is 0 leaves the select bit at 0. A write with cfg_sel = 1 while xtal_ready is 1 sets it to 1, and any write with cfg_sel = 0 clears it.
- R4: When the select bit differs from the status bit, the status bit takes the select value at the clock edge that samples the INSTR_TICKS-th (default 4) clk_en pulse of the old source. It does not change at any other time.
- R5: While amp_en is 1 and xtal_ready is 0, xtal_ready rises at the edge that samples the N-th xtal_tick, where N = warm_limit (and N = 1 when warm_limit is 0). Counting starts after reset or after the amplifier is turned back on.
- R6: A write with cfg_amp_off = 1 takes effect only when the status bit is 0, the select bit is 0 and the same write has cfg_sel = 0. Otherwise the amplifier-off bit keeps its value. An accepted set clears xtal_ready and the warm-up count at the same edge. A write with cfg_amp_off = 0 always clears the bit.
- R7: If the select bit is written back to the status value before the switch completes, the switch is cancelled. The count of ticks toward the switch is discarded.
- R8: amp_en is the inverse of the amplifier-off bit. Crystal ticks that arrive while amp_en is 0 do not advance the warm-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_sel | input | 1 | Written source select: 1 crystal, 0 RC |
| cfg_amp_off | input | 1 | Written amplifier-off bit |
| xtal_tick | input | 1 | Crystal oscillator clock-enable tick |
| rc_tick | input | 1 | RC oscillator clock-enable tick |
| warm_limit | input | WARM_W | Crystal ticks needed for warm-up |
| clk_en | output | 1 | Selected clock enable |
| amp_en | output | 1 | Crystal amplifier enable |
| sel_rd | output | 1 | Read-back of the select bit |
| amp_off_rd | output | 1 | Read-back of the amplifier-off bit |
| src_xtal | output | 1 | Status: 1 while the crystal is the source |
| xtal_ready | output | 1 | Crystal warmed up and usable |

## Verification
A wrong pending-switch count shows on src_xtal, and through it on clk_en, at the edge where the INSTR_TICKS-th old-source tick should have moved the source. An off-by-one in that count therefore appears within one tick period. A wrong warm-up count or interlock first shows on xtal_ready, and then on sel_rd at the next select write, which is refused or accepted wrongly. The bench compares every port to an arithmetic model on every cycle. Small faults therefore surface in the same cycle they first reach an output.

// File: rtl/osc_sel_pkg.sv
package osc_sel_pkg;

    typedef enum logic {
        SRC_RC   = 1'b0,
        SRC_XTAL = 1'b1
    } src_e;

    typedef struct packed {
        logic we;
        logic sel;
        logic amp_off;
    } cfg_wr_t;

    typedef struct packed {
        src_e sel;
        logic amp_off;
    } ctrl_t;

    // Amplifier may go off only with RC running, nothing pending, and no crystal request now
    function automatic logic amp_off_allowed(src_e cur, src_e sel_now, logic sel_wr);
        return (cur == SRC_RC) && (sel_now == SRC_RC) && !sel_wr;
    endfunction

    function automatic logic pick_tick(src_e cur, logic xt, logic amp_on, logic rc);
        return (cur == SRC_XTAL) ? (xt & amp_on) : rc;
    endfunction

endpackage

// File: rtl/osc_warmup.sv
module osc_warmup #(
    parameter int WARM_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              amp_on,
    input  logic              xtal_tick,
    input  logic [WARM_W-1:0] limit,
    output logic              ready
);
    logic [WARM_W-1:0] cnt_q;
    logic [WARM_W:0]   cnt_nxt;
    logic              reached;

    assign cnt_nxt = {1'b0, cnt_q} + (WARM_W+1)'(1);
    assign reached = cnt_nxt >= {1'b0, limit};

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
            ready <= 1'b0;
        end else if (amp_on && xtal_tick && !ready) begin
            if (reached) ready <= 1'b1;
            else         cnt_q <= cnt_nxt[WARM_W-1:0];
        end
    end

    AST_READY_LOW_AMP_OFF: assert property (@(posedge clk) disable iff (rst)
        !amp_on |-> !ready);  // R8
    AST_READY_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(xtal_tick && amp_on));  // R5

endmodule

// File: rtl/osc_switch_delay.sv
module osc_switch_delay
    import osc_sel_pkg::*;
#(
    parameter int INSTR_TICKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  src_e sel,
    input  logic tick,
    output src_e cur
);
    localparam int CNT_W = $clog2(INSTR_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(INSTR_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             pending;

    assign pending = (sel != cur);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur   <= SRC_RC;
            cnt_q <= '0;
        end else if (!pending) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (cnt_q == LAST) begin
                cur   <= sel;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    AST_SRC_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (cur != $past(cur)) |-> $past(tick && pending));  // R4
    AST_PEND_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CNT_W'(INSTR_TICKS));  // R4
    AST_IDLE_CLEARS_COUNT: assert property (@(posedge clk) disable iff (rst)
        !pending |=> (cnt_q == '0));  // R7

endmodule

// File: rtl/osc_source_select.sv
module osc_source_select
    import osc_sel_pkg::*;
#(
    parameter int WARM_W      = 8,
    parameter int INSTR_TICKS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic              cfg_amp_off,
    input  logic              xtal_tick,
    input  logic              rc_tick,
    input  logic [WARM_W-1:0] warm_limit,
    output logic              clk_en,
    output logic              amp_en,
    output logic              sel_rd,
    output logic              amp_off_rd,
    output logic              src_xtal,
    output logic              xtal_ready
);
    cfg_wr_t wr;
    ctrl_t   ctrl_q;
    src_e    cur;
    logic    amp_set_ok;
    logic    sel_is_xtal;

    assign wr = '{we: cfg_we, sel: cfg_sel, amp_off: cfg_amp_off};

    assign amp_set_ok = wr.we && wr.amp_off && !ctrl_q.amp_off
                        && amp_off_allowed(cur, ctrl_q.sel, wr.sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.sel     <= SRC_RC;
            ctrl_q.amp_off <= 1'b0;
        end else if (wr.we) begin
            ctrl_q.sel     <= (wr.sel && xtal_ready) ? SRC_XTAL : SRC_RC;
            ctrl_q.amp_off <= wr.amp_off ? (ctrl_q.amp_off | amp_set_ok) : 1'b0;
        end
    end

    osc_warmup #(.WARM_W(WARM_W)) i_warmup (
        .clk       (clk),
        .rst       (rst),
        .restart   (amp_set_ok),
        .amp_on    (amp_en),
        .xtal_tick (xtal_tick),
        .limit     (warm_limit),
        .ready     (xtal_ready)
    );

    osc_switch_delay #(.INSTR_TICKS(INSTR_TICKS)) i_switch (
        .clk  (clk),
        .rst  (rst),
        .sel  (ctrl_q.sel),
        .tick (clk_en),
        .cur  (cur)
    );

    assign amp_en      = !ctrl_q.amp_off;
    assign clk_en      = pick_tick(cur, xtal_tick, amp_en, rc_tick);
    assign sel_rd      = (ctrl_q.sel == SRC_XTAL);
    assign amp_off_rd  = ctrl_q.amp_off;
    assign src_xtal    = (cur == SRC_XTAL);
    assign sel_is_xtal = sel_rd;

    AST_SEL_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
        $rose(sel_is_xtal) |-> $past(xtal_ready));  // R3
    AST_AMP_OFF_ON_RC: assert property (@(posedge clk) disable iff (rst)
        amp_off_rd |-> !src_xtal);  // R6
    AST_AMP_OFF_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        amp_off_rd |-> !xtal_ready);  // R6

endmodule

// File: tb/test_osc_source_select.sv
module test_osc_source_select;
    localparam int CLK_PERIOD = 10;
    localparam int WW = 8;
    localparam int IT = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 0, cfg_sel = 0, cfg_amp_off = 0, xtal_tick = 0, rc_tick = 0;
    logic [WW-1:0] warm_limit = '0;
    logic clk_en, amp_en, sel_rd, amp_off_rd, src_xtal, xtal_ready;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    bit m_sel, m_cur, m_amp, m_ready;
    int m_wcnt, m_icnt;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    osc_source_select #(.WARM_W(WW), .INSTR_TICKS(IT)) i_osc_source_select (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_amp_off(cfg_amp_off), .xtal_tick(xtal_tick), .rc_tick(rc_tick),
        .warm_limit(warm_limit), .clk_en(clk_en), .amp_en(amp_en),
        .sel_rd(sel_rd), .amp_off_rd(amp_off_rd), .src_xtal(src_xtal),
        .xtal_ready(xtal_ready));

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_regs();
        chk("R3 sel_rd", sel_rd, m_sel);
        chk("R4 src_xtal", src_xtal, m_cur);
        chk("R6 amp_off_rd", amp_off_rd, m_amp);
        chk("R8 amp_en", amp_en, !m_amp);
        chk("R5 xtal_ready", xtal_ready, m_ready);
    endtask

    task automatic cyc(input bit we, input bit s, input bit ao, input bit xt, input bit rc);
        bit en, acc;
        int lim;
        cfg_we = we; cfg_sel = s; cfg_amp_off = ao; xtal_tick = xt; rc_tick = rc;
        #1;
        en = m_cur ? (xt & !m_amp) : rc;
        chk("R2 clk_en", clk_en, en);
        lim = (warm_limit == 0) ? 1 : int'(warm_limit);
        acc = we && ao && !m_amp && !m_cur && !m_sel && !s;
        // source switch uses the select value before this write
        if (m_sel == m_cur) m_icnt = 0;
        else if (en) begin
            if (m_icnt == IT - 1) begin m_cur = m_sel; m_icnt = 0; end
            else m_icnt++;
        end
        // warm-up
        if (acc) begin m_ready = 0; m_wcnt = 0; end
        else if (!m_amp && xt && !m_ready) begin
            if (m_wcnt + 1 >= lim) m_ready = 1; else m_wcnt++;
        end
        if (we) begin
            m_sel = s && xtal_ready_model_prev(acc);
            m_amp = ao ? (m_amp | acc) : 1'b0;
        end
        @(posedge clk); #1;
        chk_regs();
    endtask

    // select acceptance uses ready before this edge
    bit ready_before;
    function automatic bit xtal_ready_model_prev(input bit dummy);
        return ready_before;
    endfunction

    task automatic step(input bit we, input bit s, input bit ao, input bit xt, input bit rc);
        ready_before = m_ready;
        cyc(we, s, ao, xt, rc);
    endtask

    task automatic run(input int n, input int p);
        for (int i = 0; i < n; i++) step(0, 0, 0, (i % p) == 0, (i % (p + 1)) == 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        m_sel = 0; m_cur = 0; m_amp = 0; m_ready = 0; m_wcnt = 0; m_icnt = 0;
        // R1 reset state
        chk("R1 sel_rd", sel_rd, 0);
        chk("R1 src_xtal", src_xtal, 0);
        chk("R1 amp_en", amp_en, 1);
        chk("R1 xtal_ready", xtal_ready, 0);
        rc_tick = 1; #1 chk("R1 clk_en follows rc", clk_en, 1);
        rc_tick = 0; #1 chk("R1 clk_en follows rc", clk_en, 0);

        // R3: crystal request before warm-up is refused
        warm_limit = 8'd3;
        step(1, 1, 0, 0, 1);
        chk("R3 refused before ready", sel_rd, 0);
        run(4, 1);
        chk("R5 ready after 3 ticks", xtal_ready, 1);

        // R7: cancel a pending switch
        step(1, 1, 0, 0, 1);
        step(0, 0, 0, 0, 1);
        step(1, 0, 0, 0, 1);
        for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 1);
        chk("R7 switch cancelled", src_xtal, 0);

        // sweep tick spacing and warm-up length
        for (int p = 1; p <= 3; p++) begin
            for (int lim = 0; lim <= 4; lim++) begin
                warm_limit = WW'(lim);
                step(1, 0, 0, 0, 0);
                run(4 * p + 8, p);
                step(1, 0, 1, 0, 0);                 // R6 amp off accepted on RC
                run(5, p);
                step(1, 0, 0, 0, 0);
                run((lim + 2) * p + 2, p);
                step(1, 1, 0, 0, 0);
                run(6 * (p + 1) + 4, p);
                step(1, 1, 1, 0, 0);                 // R6 ignored on crystal
                chk("R6 ignored while crystal", amp_off_rd, 0);
                run(3, p);
                step(1, 0, 0, 0, 0);
                run(6 * p + 4, p);
            end
        end

        // pseudo-random phase
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[15:13] == 3'd0) warm_limit = WW'(lfsr[2:0]);
            step(lfsr[4:2] == 3'd0, lfsr[5], lfsr[6] & lfsr[7], lfsr[8], lfsr[9] | lfsr[11]);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule